// File: doc/BRIEF.md
# Eager Transactional Conflict Detector

This per-core unit follows the cache lines that the running hardware transaction has touched. A small direct-mapped array holds one tag, one read mark and one write mark per slot. Loads made inside a transaction set the read mark of their line, and stores set the write mark. Every incoming coherence snoop is compared with these marks in the cycle it arrives, so conflicts are found eagerly rather than at commit.

When a snoop conflicts, a static policy input picks what happens. Under requester-wins, the snoop proceeds and the local transaction is told to abort. Under requester-stalls, the snoop is refused and its sender retries. In that mode the unit tracks transaction age to catch a possible deadlock. Each transaction takes its age stamp from a global counter when it begins, and keeps that stamp when it retries after an abort.

The core drives begin, commit and abort strobes and its own loads and stores. The core also reports when one of its own requests has been refused by another core. The unit answers each snoop and raises a local abort request. Register checkpointing, data versioning and the coherence protocol itself belong to other blocks.

Top module: `txn_conflict_unit`

## Requirements
- R1: After reset no transaction is open, `snp_resp_o` reads 0 and `abort_req_o` is low.
- R2: While no transaction is open, or while an abort request is pending, every snoop gets response 0. Loads and stores made outside a transaction leave no mark.
- R3: A load inside a live transaction marks its line as read, and a store marks it as written. A line is identified by slot index `addr[LINE_OFF+IDX_W-1:LINE_OFF]` and tag `addr[ADDR_W-1:LINE_OFF+IDX_W]`. A snoop conflicts when it is a write that hits a read or written line, or a read that hits a written line. A read that hits a line only read, or any snoop that misses, is answered 0. The response is combinational in the snoop's cycle and is encoded as 0 = proceed, 1 = refuse and retry, 2 = proceed while the local transaction aborts.
- R4: With `policy_stall_i` = 0, a conflicting snoop gets response 2. `abort_req_o` goes high on the next cycle and stays high until an abort or commit strobe.
- R5: With `policy_stall_i` = 1, a conflicting snoop gets response 1, and the conflict by itself raises no abort.
- R6: Refusing a snoop whose stamp is smaller (older) than the local stamp sets a sticky possible-cycle flag. While the flag is set, `own_nack_i` with an `own_nack_ts_i` older than the local stamp raises `abort_req_o` on the next cycle. Without the flag, or with a younger refuser, it does not.
- R7: A load or store whose slot holds a different line that carries a read or write mark raises `abort_req_o` on the next cycle. A repeated access to an already marked line does not.
- R8: A commit or abort strobe ends the transaction. It clears all marks, the possible-cycle flag and any pending abort, so a later transaction sees empty sets. Abort has priority over commit, and commit has priority over begin.
- R9: A begin following a commit, or the first begin after reset, samples `ts_now_i` as the local stamp. A begin following an abort keeps the stamp of the aborted attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_stall_i | input | 1 | 0 = requester wins, 1 = requester stalls |
| ts_now_i | input | TS_W | Global free-running age counter |
| tx_begin_i | input | 1 | Begin strobe |
| tx_commit_i | input | 1 | Commit strobe |
| tx_abort_i | input | 1 | Abort strobe |
| acc_valid_i | input | 1 | Local load or store valid |
| acc_write_i | input | 1 | Local access is a store |
| acc_addr_i | input | ADDR_W | Local access address |
| snp_valid_i | input | 1 | Incoming snoop valid |
| snp_write_i | input | 1 | Snoop requests write ownership |
| snp_addr_i | input | ADDR_W | Snoop address |
| snp_ts_i | input | TS_W | Stamp of the snoop sender |
| own_nack_i | input | 1 | A local request was refused by another core |
| own_nack_ts_i | input | TS_W | Stamp of the core that refused it |
| snp_resp_o | output | 2 | Snoop response (0 proceed, 1 retry, 2 proceed and local abort) |
| abort_req_o | output | 1 | Local abort request, held until abort or commit |

## Verification
The snoop response is combinational, so it is due in the same cycle as the snoop, based on the marks and flags as they stood before that clock edge. The abort request, new marks, the possible-cycle flag and a captured stamp all become visible one edge later. The bench drives inputs on the falling edge and samples both outputs one nanosecond later. It advances its reference model just after the rising edge, so every check compares against the state as of the previous edge. Directed sequences make conflicts, overflow, deadlock and stamp retention land in known cycles. The random phase uses a few addresses that share slots, so hits, misses and slot clashes occur often.

// File: rtl/txcd_pkg.sv
package txcd_pkg;
  typedef enum logic [1:0] {
    SNP_OK    = 2'd0,
    SNP_NACK  = 2'd1,
    SNP_YIELD = 2'd2
  } snp_resp_e;
endpackage

// File: rtl/txcd_line_sets.sv
module txcd_line_sets #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rec_en_i,
  input  logic              rec_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              acc_clash_o,
  output logic              snp_hit_r_o,
  output logic              snp_hit_w_o
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - LINE_OFF - IDX_W;

  logic [IDX_W-1:0] acc_idx, snp_idx;
  logic [TAG_W-1:0] acc_tag, snp_tag;
  logic [SLOTS-1:0] rd_bits, wr_bits;
  logic [TAG_W-1:0] tag_arr [SLOTS];

  assign acc_idx = acc_addr_i[LINE_OFF +: IDX_W];
  assign snp_idx = snp_addr_i[LINE_OFF +: IDX_W];
  assign acc_tag = acc_addr_i[ADDR_W-1 -: TAG_W];
  assign snp_tag = snp_addr_i[ADDR_W-1 -: TAG_W];

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic             rd_q, wr_q, rd_d, wr_d, sel;
      logic [TAG_W-1:0] tag_q;

      assign sel = rec_en_i && (acc_idx == IDX_W'(s));

      always_comb begin
        rd_d = rd_q;
        wr_d = wr_q;
        if (clear_i) begin
          rd_d = 1'b0;
          wr_d = 1'b0;
        end else if (sel) begin
          if (rec_write_i) wr_d = 1'b1;
          else             rd_d = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_q <= 1'b0;
          wr_q <= 1'b0;
        end else begin
          rd_q <= rd_d;
          wr_q <= wr_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                tag_q <= '0;
        else if (sel && !clear_i)  tag_q <= acc_tag;
      end

      assign rd_bits[s] = rd_q;
      assign wr_bits[s] = wr_q;
      assign tag_arr[s] = tag_q;
    end
  endgenerate

  assign acc_clash_o = (rd_bits[acc_idx] || wr_bits[acc_idx]) &&
                       (tag_arr[acc_idx] != acc_tag);
  assign snp_hit_r_o = rd_bits[snp_idx] && (tag_arr[snp_idx] == snp_tag);
  assign snp_hit_w_o = wr_bits[snp_idx] && (tag_arr[snp_idx] == snp_tag);

  // R8: a clear leaves no mark behind
  p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> ((rd_bits | wr_bits) == '0));
  // R3: a recorded store leaves the write mark in its slot
  p_store_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_en_i && rec_write_i && !clear_i) |=> wr_bits[$past(acc_idx)]);
endmodule

// File: rtl/txcd_txn_state.sv
module txcd_txn_state #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            begin_i,
  input  logic            commit_i,
  input  logic            abort_i,
  input  logic [TS_W-1:0] ts_now_i,
  input  logic            raise_abort_i,
  input  logic            nacked_older_i,
  output logic            active_o,
  output logic            pend_o,
  output logic            cycle_o,
  output logic [TS_W-1:0] ts_o
);
  logic            active_q, active_d;
  logic            pend_q, pend_d;
  logic            cyc_q, cyc_d;
  logic            keep_q, keep_d;
  logic [TS_W-1:0] ts_q;
  logic            ts_en;

  always_comb begin
    active_d = active_q;
    pend_d   = pend_q;
    cyc_d    = cyc_q;
    keep_d   = keep_q;
    ts_en    = 1'b0;
    if (abort_i) begin
      active_d = 1'b0;
      pend_d   = 1'b0;
      cyc_d    = 1'b0;
      if (active_q) keep_d = 1'b1;
    end else if (commit_i) begin
      active_d = 1'b0;
      pend_d   = 1'b0;
      cyc_d    = 1'b0;
      if (active_q) keep_d = 1'b0;
    end else if (begin_i && !active_q) begin
      active_d = 1'b1;
      ts_en    = !keep_q;
    end else if (active_q && !pend_q) begin
      if (raise_abort_i)  pend_d = 1'b1;
      if (nacked_older_i) cyc_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      cyc_q    <= 1'b0;
      keep_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      pend_q   <= pend_d;
      cyc_q    <= cyc_d;
      keep_q   <= keep_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ts_q <= '0;
    else if (ts_en) ts_q <= ts_now_i;
  end

  assign active_o = active_q;
  assign pend_o   = pend_q;
  assign cycle_o  = cyc_q;
  assign ts_o     = ts_q;

  // R4: a pending abort request persists until the transaction ends
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !abort_i && !commit_i) |=> pend_q);
  // R8: ending a transaction clears every flag
  p_end_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i || commit_i) |=> (!active_q && !pend_q && !cyc_q));
  // R9: a retry keeps its stamp
  p_ts_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_i && !abort_i && !commit_i && !active_q && keep_q) |=> $stable(ts_q));
  // R9: a fresh transaction samples the global counter
  p_ts_fresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_i && !abort_i && !commit_i && !active_q && !keep_q) |=> (ts_q == $past(ts_now_i)));
endmodule

// File: rtl/txcd_resolver.sv
module txcd_resolver
  import txcd_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic            policy_stall_i,
  input  logic            live_i,
  input  logic            snp_valid_i,
  input  logic            snp_write_i,
  input  logic            hit_r_i,
  input  logic            hit_w_i,
  input  logic [TS_W-1:0] snp_ts_i,
  input  logic [TS_W-1:0] own_ts_i,
  input  logic            cycle_i,
  input  logic            own_nack_i,
  input  logic [TS_W-1:0] own_nack_ts_i,
  output snp_resp_e       resp_o,
  output logic            yield_o,
  output logic            nack_older_o,
  output logic            deadlock_o
);
  logic conflict;

  assign conflict = live_i && snp_valid_i &&
                    (snp_write_i ? (hit_r_i || hit_w_i) : hit_w_i);

  always_comb begin
    resp_o = SNP_OK;
    if (conflict) resp_o = policy_stall_i ? SNP_NACK : SNP_YIELD;
  end

  assign yield_o      = conflict && !policy_stall_i;
  assign nack_older_o = conflict && policy_stall_i && (snp_ts_i < own_ts_i);
  assign deadlock_o   = live_i && own_nack_i && cycle_i && (own_nack_ts_i < own_ts_i);
endmodule

// File: rtl/txn_conflict_unit.sv
module txn_conflict_unit
  import txcd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int IDX_W    = 4,
  parameter int TS_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              policy_stall_i,
  input  logic [TS_W-1:0]   ts_now_i,
  input  logic              tx_begin_i,
  input  logic              tx_commit_i,
  input  logic              tx_abort_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              snp_valid_i,
  input  logic              snp_write_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [TS_W-1:0]   snp_ts_i,
  input  logic              own_nack_i,
  input  logic [TS_W-1:0]   own_nack_ts_i,
  output logic [1:0]        snp_resp_o,
  output logic              abort_req_o
);
  logic            active, pend, cyc, live, tx_end;
  logic [TS_W-1:0] own_ts;
  logic            clash, hit_r, hit_w, rec_en;
  logic            yield, nack_older, deadlock, raise_abort;
  snp_resp_e       resp;

  assign live        = active && !pend;
  assign tx_end      = tx_abort_i || tx_commit_i;
  assign rec_en      = live && acc_valid_i && !clash && !tx_end;
  assign raise_abort = live && (yield || deadlock || (acc_valid_i && clash));

  txcd_line_sets #(
    .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .IDX_W(IDX_W)
  ) i_sets (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (tx_end),
    .rec_en_i   (rec_en),
    .rec_write_i(acc_write_i),
    .acc_addr_i (acc_addr_i),
    .snp_addr_i (snp_addr_i),
    .acc_clash_o(clash),
    .snp_hit_r_o(hit_r),
    .snp_hit_w_o(hit_w)
  );

  txcd_txn_state #(.TS_W(TS_W)) i_state (
    .clk           (clk),
    .rst_n         (rst_n),
    .begin_i       (tx_begin_i),
    .commit_i      (tx_commit_i),
    .abort_i       (tx_abort_i),
    .ts_now_i      (ts_now_i),
    .raise_abort_i (raise_abort),
    .nacked_older_i(nack_older),
    .active_o      (active),
    .pend_o        (pend),
    .cycle_o       (cyc),
    .ts_o          (own_ts)
  );

  txcd_resolver #(.TS_W(TS_W)) i_resolve (
    .policy_stall_i(policy_stall_i),
    .live_i        (live),
    .snp_valid_i   (snp_valid_i),
    .snp_write_i   (snp_write_i),
    .hit_r_i       (hit_r),
    .hit_w_i       (hit_w),
    .snp_ts_i      (snp_ts_i),
    .own_ts_i      (own_ts),
    .cycle_i       (cyc),
    .own_nack_i    (own_nack_i),
    .own_nack_ts_i (own_nack_ts_i),
    .resp_o        (resp),
    .yield_o       (yield),
    .nack_older_o  (nack_older),
    .deadlock_o    (deadlock)
  );

  assign snp_resp_o  = resp;
  assign abort_req_o = pend;

  // R2: no transaction, no refusal
  p_idle_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (snp_resp_o == 2'(SNP_OK)));
  // R3: a read snoop that hits no written line always proceeds
  p_readread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid_i && !snp_write_i && !hit_w) |-> (snp_resp_o == 2'(SNP_OK)));
  // R4: yielding to a requester leads to a local abort request
  p_yield_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_resp_o == 2'(SNP_YIELD) && !tx_end) |=> abort_req_o);
  // R5: refusals only in stall mode
  p_nack_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_resp_o == 2'(SNP_NACK)) |-> policy_stall_i);
  // R6: refused by an older core after refusing an older one
  p_deadlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && own_nack_i && cyc && (own_nack_ts_i < own_ts) && !tx_end) |=> abort_req_o);
  // R7: a slot clash cannot be tracked
  p_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && acc_valid_i && clash && !tx_end) |=> abort_req_o);
endmodule

// File: tb/test_txn_conflict_unit.sv
module test_txn_conflict_unit;
  localparam int ADDR_W = 32, LINE_OFF = 6, IDX_W = 4, TS_W = 16;
  localparam int SLOTS = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - LINE_OFF - IDX_W;

  logic clk, rst_n, policy_stall_i;
  logic [TS_W-1:0] ts_now_i, snp_ts_i, own_nack_ts_i;
  logic tx_begin_i, tx_commit_i, tx_abort_i;
  logic acc_valid_i, acc_write_i, snp_valid_i, snp_write_i, own_nack_i;
  logic [ADDR_W-1:0] acc_addr_i, snp_addr_i;
  logic [1:0] snp_resp_o;
  logic abort_req_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [TS_W-1:0] gts = '0;

  bit m_rd [SLOTS], m_wr [SLOTS];
  logic [TAG_W-1:0] m_tag [SLOTS];
  bit m_act, m_pend, m_cyc, m_keep;
  logic [TS_W-1:0] m_ts;

  localparam logic [ADDR_W-1:0] LA = 32'h0000_0400; // tag 1, slot 0
  localparam logic [ADDR_W-1:0] LB = 32'h0000_0800; // tag 2, slot 0
  localparam logic [ADDR_W-1:0] LC = 32'h0000_0440; // tag 1, slot 1

  txn_conflict_unit i_txn_conflict_unit (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int model_resp();
    int i = int'(snp_addr_i[LINE_OFF +: IDX_W]);
    bit hr = m_rd[i] && (m_tag[i] == snp_addr_i[ADDR_W-1 -: TAG_W]);
    bit hw = m_wr[i] && (m_tag[i] == snp_addr_i[ADDR_W-1 -: TAG_W]);
    bit conf;
    if (!(m_act && !m_pend && snp_valid_i)) return 0;
    conf = snp_write_i ? (hr || hw) : hw;
    if (!conf) return 0;
    return policy_stall_i ? 1 : 2;
  endfunction

  task automatic model_clear();
    for (int s = 0; s < SLOTS; s++) begin m_rd[s] = 0; m_wr[s] = 0; end
    m_act = 0; m_pend = 0; m_cyc = 0;
  endtask

  task automatic model_update();
    int r = model_resp();
    int ai = int'(acc_addr_i[LINE_OFF +: IDX_W]);
    logic [TAG_W-1:0] at = acc_addr_i[ADDR_W-1 -: TAG_W];
    bit clash = (m_rd[ai] || m_wr[ai]) && (m_tag[ai] != at);
    bit np;
    if (tx_abort_i) begin
      if (m_act) m_keep = 1;
      model_clear();
    end else if (tx_commit_i) begin
      if (m_act) m_keep = 0;
      model_clear();
    end else if (tx_begin_i && !m_act) begin
      m_act = 1;
      if (!m_keep) m_ts = ts_now_i;
    end else if (m_act && !m_pend) begin
      np = (r == 2) || (acc_valid_i && clash) ||
           (own_nack_i && m_cyc && (own_nack_ts_i < m_ts));
      if (r == 1 && snp_ts_i < m_ts) m_cyc = 1;
      if (acc_valid_i && !clash) begin
        if (acc_write_i) m_wr[ai] = 1; else m_rd[ai] = 1;
        m_tag[ai] = at;
      end
      if (np) m_pend = 1;
    end
  endtask

  task automatic run_cycle();
    ts_now_i = gts;
    #1;
    chk(int'(snp_resp_o), model_resp(), "R3/R4/R5 snoop response vs model");
    chk(int'(abort_req_o), int'(m_pend), "R4/R6/R7 abort request vs model");
    @(posedge clk);
    model_update();
    gts = gts + 1'b1;
    @(negedge clk);
  endtask

  task automatic idle_in();
    tx_begin_i = 0; tx_commit_i = 0; tx_abort_i = 0;
    acc_valid_i = 0; acc_write_i = 0; acc_addr_i = '0;
    snp_valid_i = 0; snp_write_i = 0; snp_addr_i = '0; snp_ts_i = '0;
    own_nack_i = 0; own_nack_ts_i = '0;
  endtask

  task automatic do_acc(input logic [ADDR_W-1:0] a, input bit w);
    idle_in(); acc_valid_i = 1; acc_write_i = w; acc_addr_i = a; run_cycle();
  endtask

  task automatic do_snp(input logic [ADDR_W-1:0] a, input bit w,
                        input logic [TS_W-1:0] ts, input int exp, input string what);
    idle_in(); snp_valid_i = 1; snp_write_i = w; snp_addr_i = a; snp_ts_i = ts;
    #1; chk(int'(snp_resp_o), exp, what);
    run_cycle();
  endtask

  task automatic strobe(input bit b, input bit c, input bit a);
    idle_in(); tx_begin_i = b; tx_commit_i = c; tx_abort_i = a; run_cycle();
  endtask

  task automatic own_nack(input logic [TS_W-1:0] ts);
    idle_in(); own_nack_i = 1; own_nack_ts_i = ts; run_cycle();
  endtask

  initial begin
    logic [TS_W-1:0] g1;
    void'($urandom(32'd20240611));
    rst_n = 0; policy_stall_i = 0; ts_now_i = '0; idle_in();
    for (int s = 0; s < SLOTS; s++) m_tag[s] = '0;
    model_clear(); m_keep = 0; m_ts = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(int'(snp_resp_o), 0, "R1 reset response");
    chk(int'(abort_req_o), 0, "R1 reset abort request");
    run_cycle();

    // R2: idle snoops and idle accesses
    do_snp(LA, 1, 16'd0, 0, "R2 snoop while idle");
    do_acc(LA, 1);
    strobe(1, 0, 0);
    do_snp(LA, 0, 16'd0, 0, "R2 idle store left no mark");

    // R3/R4 requester wins
    do_acc(LA, 0);
    do_snp(LA, 0, 16'd0, 0, "R3 read-read is no conflict");
    do_snp(LC, 1, 16'd0, 0, "R3 write miss is no conflict");
    do_snp(LA | 32'h4, 1, 16'd0, 2, "R4 remote write hits read line");
    #1; chk(int'(abort_req_o), 1, "R4 abort request next cycle");
    do_snp(LA, 1, 16'd0, 0, "R2 snoop while abort pending");
    #1; chk(int'(abort_req_o), 1, "R4 abort request held");
    strobe(0, 0, 1);
    #1; chk(int'(abort_req_o), 0, "R4 abort request dropped by abort");
    strobe(1, 0, 0);
    do_acc(LC, 1);
    do_snp(LC, 0, 16'd0, 2, "R3 remote read hits written line");
    strobe(0, 0, 1);

    // R8 clear on commit
    strobe(1, 0, 0);
    do_acc(LA, 0);
    strobe(0, 1, 0);
    strobe(1, 0, 0);
    do_snp(LA, 1, 16'd0, 0, "R8 commit cleared read set");

    // R7 overflow
    do_acc(LA, 0);
    do_acc(LA, 1);
    #1; chk(int'(abort_req_o), 0, "R7 same line no overflow");
    do_acc(LB, 0);
    #1; chk(int'(abort_req_o), 1, "R7 slot clash overflow");
    strobe(0, 1, 0);

    // R5/R6 requester stalls
    policy_stall_i = 1;
    strobe(1, 0, 0);
    g1 = m_ts;
    do_acc(LA, 1);
    do_snp(LA, 0, g1 + 16'd1000, 1, "R5 conflict refused");
    #1; chk(int'(abort_req_o), 0, "R5 refusal raises no abort");
    own_nack(16'd0);
    #1; chk(int'(abort_req_o), 0, "R6 no flag no abort");
    do_snp(LA, 0, 16'd0, 1, "R5 older requester refused");
    own_nack(g1 + 16'd500);
    #1; chk(int'(abort_req_o), 0, "R6 younger refuser no abort");
    own_nack(16'd0);
    #1; chk(int'(abort_req_o), 1, "R6 possible deadlock abort");
    strobe(0, 0, 1);

    // R9 stamp retention
    strobe(1, 0, 0);
    g1 = gts - 16'd1;
    do_acc(LA, 0);
    strobe(0, 0, 1);
    repeat (20) begin idle_in(); run_cycle(); end
    strobe(1, 0, 0);
    do_acc(LA, 1);
    do_snp(LA, 0, g1 + 16'd5, 1, "R9 retry refuses");
    own_nack(16'd0);
    #1; chk(int'(abort_req_o), 0, "R9 retry kept old stamp");
    strobe(0, 1, 0);
    repeat (5) begin idle_in(); run_cycle(); end
    strobe(1, 0, 0);
    do_acc(LA, 1);
    do_snp(LA, 0, g1 + 16'd5, 1, "R9 fresh refuses");
    own_nack(16'd0);
    #1; chk(int'(abort_req_o), 1, "R9 fresh stamp sampled");
    strobe(0, 0, 1);

    // random phases, both policies
    for (int p = 0; p < 2; p++) begin
      policy_stall_i = (p == 1);
      for (int i = 0; i < 3000; i++) begin
        idle_in();
        tx_begin_i  = ($urandom_range(0, 99) < 10);
        tx_commit_i = ($urandom_range(0, 99) < 3);
        tx_abort_i  = ($urandom_range(0, 99) < 3);
        acc_valid_i = ($urandom_range(0, 1) == 1);
        acc_write_i = ($urandom_range(0, 1) == 1);
        acc_addr_i  = {TAG_W'($urandom_range(1, 2)), IDX_W'($urandom_range(0, 2)),
                       LINE_OFF'($urandom_range(0, 63))};
        snp_valid_i = ($urandom_range(0, 1) == 1);
        snp_write_i = ($urandom_range(0, 1) == 1);
        snp_addr_i  = {TAG_W'($urandom_range(1, 2)), IDX_W'($urandom_range(0, 2)),
                       LINE_OFF'($urandom_range(0, 63))};
        snp_ts_i    = TS_W'(m_ts + TS_W'($urandom_range(0, 80)) - 16'd40);
        own_nack_i  = ($urandom_range(0, 99) < 10);
        own_nack_ts_i = TS_W'(m_ts + TS_W'($urandom_range(0, 80)) - 16'd40);
        run_cycle();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule